// File: doc/BRIEF.md
# Multi-core frequency request resolver

This block takes a performance request from every core of a multi-core chip and turns them into one frequency ratio for the whole chip. Each request is a ratio of a 133 MHz bin. The chip-wide target is the largest request among the cores that are awake. A sleeping core keeps its request, but that request only counts again once the core wakes.

When the target moves, every core receives the new ratio. A core does not take it at once. It adopts the ratio only when it reports, through a per-core ready strobe, that its instruction stream has reached an interruptible boundary. Each core therefore switches on its own cycle, and for a short time the cores may run at different ratios.

A status output is high while any core's applied ratio differs from the target. PLL sequencing and voltage control are handled outside this block.

Top module: `freq_resolver_top`

## Requirements
- R1: `target_ratio` is registered. One clock edge after the inputs are presented, it equals the largest clamped request among the awake cores.
- R2: A core whose `core_sleep` bit is 1 does not take part in the maximum. When that core wakes, its request counts again from the next edge.
- R3: When every core is asleep, `target_ratio` is the floor ratio 9, which is 1.2 GHz.
- R4: Before the maximum is taken, each request is clamped into the range from FLOOR_RATIO (9) to MAX_RATIO (26 by default).
- R5: `target_chg` is high for exactly the cycles in which `target_ratio` holds a value different from the one it held in the previous cycle.
- R6: On the edge where the target changes, every core records the new ratio as pending. A core's `core_ratio` does not change until that core's ready strobe arrives.
- R7: On the first edge where a core's `core_ready` bit is 1 and an update is pending, that core's `core_ratio` takes the pending ratio and the pending state clears. A ready strobe with nothing pending leaves `core_ratio` unchanged.
- R8: If the target changes again before a core has applied its pending update, the pending ratio is replaced by the newest target.
- R9: `ratio_skew` is registered. It is high exactly when at least one core's `core_ratio` differs from `target_ratio`.
- R10: Synchronous reset sets `target_ratio` and every `core_ratio` to 9, sets `target_chg` and `ratio_skew` to 0, and clears all pending updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | N_CORES*6 | Requested ratio per core; core i is in bits [6i+5:6i] |
| core_sleep | input | N_CORES | 1 = the core is asleep and is left out of the maximum |
| core_ready | input | N_CORES | 1 = the core is at an instruction boundary and may switch |
| core_ratio | output | N_CORES*6 | Ratio each core currently applies, packed like core_req |
| target_ratio | output | 6 | Resolved chip-wide ratio |
| target_chg | output | 1 | One-cycle pulse when target_ratio takes a new value |
| ratio_skew | output | 1 | High while any core_ratio differs from target_ratio |

## Verification
Requests and sleep flags presented before an edge show up in `target_ratio` and `target_chg` right after that edge. That is one register stage. A ready strobe moves `core_ratio` at the same edge it is sampled, and `ratio_skew` reflects the state after that edge. The bench drives inputs on the falling edge and updates its reference model for the coming rising edge. It then compares every output at the next falling edge, so each result is checked in the cycle it is due. Directed steps cover:
- the all-asleep floor,
- clamping at both ends,
- a wake that raises the target,
- a pending overwrite across two changes,
- an idle ready strobe.

// File: rtl/freq_pkg.sv
package freq_pkg;
  localparam int RATIO_W = 6;
  typedef logic [RATIO_W-1:0] ratio_t;
  localparam int FLOOR_RATIO_DEF = 9;
  localparam int MAX_RATIO_DEF = 26;
endpackage

// File: rtl/ratio_clamp.sv
module ratio_clamp
  import freq_pkg::*;
#(
  parameter int LO = FLOOR_RATIO_DEF,
  parameter int HI = MAX_RATIO_DEF
) (
  input  ratio_t raw_i,
  output ratio_t lim_o
);
  localparam ratio_t LO_R = ratio_t'(LO);
  localparam ratio_t HI_R = ratio_t'(HI);

  always_comb begin
    if (raw_i < LO_R)      lim_o = LO_R;
    else if (raw_i > HI_R) lim_o = HI_R;
    else                   lim_o = raw_i;
  end
endmodule

// File: rtl/active_max.sv
module active_max
  import freq_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int FLOOR   = FLOOR_RATIO_DEF
) (
  input  ratio_t [N_CORES-1:0] lim_i,
  input  logic   [N_CORES-1:0] sleep_i,
  output ratio_t               best_o
);
  // Inputs are already clamped at or above FLOOR, so starting from FLOOR
  // also covers the case where every core is asleep.
  always_comb begin
    best_o = ratio_t'(FLOOR);
    for (int i = 0; i < N_CORES; i++) begin
      if (!sleep_i[i] && (lim_i[i] > best_o)) best_o = lim_i[i];
    end
  end
endmodule

// File: rtl/core_apply_slot.sv
module core_apply_slot
  import freq_pkg::*;
#(
  parameter int FLOOR = FLOOR_RATIO_DEF
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   rdy_i,
  input  logic   chg_i,
  input  ratio_t nxt_i,
  output ratio_t app_o,
  output ratio_t app_d_o
);
  logic   pend_q;
  ratio_t pend_r_q;
  ratio_t app_q;

  // Value the applied ratio will hold after the coming edge.
  assign app_d_o = (rdy_i && pend_q) ? pend_r_q : app_q;
  assign app_o   = app_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      pend_r_q <= ratio_t'(FLOOR);
      app_q    <= ratio_t'(FLOOR);
    end else begin
      if (rdy_i && pend_q) begin
        app_q  <= pend_r_q;
        pend_q <= 1'b0;
      end
      // A new target always leaves an update pending. If it arrives in the
      // same cycle as a ready strobe, it replaces the value just consumed.
      if (chg_i) begin
        pend_q   <= 1'b1;
        pend_r_q <= nxt_i;
      end
    end
  end

  assert_pend_capture_R6: assert property (@(posedge clk) disable iff (rst)
    $past(chg_i) |-> (pend_q && (pend_r_q == $past(nxt_i))));

  assert_pend_overwrite_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(chg_i) && $past(pend_q) && !$past(rdy_i)) |-> (pend_r_q == $past(nxt_i)));

  assert_apply_take_R7: assert property (@(posedge clk) disable iff (rst)
    $past(rdy_i && pend_q) |-> (app_q == $past(pend_r_q)));

  assert_apply_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rdy_i && pend_q) |-> $stable(app_q));
endmodule

// File: rtl/freq_resolver_top.sv
module freq_resolver_top
  import freq_pkg::*;
#(
  parameter int N_CORES     = 4,
  parameter int FLOOR_RATIO = FLOOR_RATIO_DEF,
  parameter int MAX_RATIO   = MAX_RATIO_DEF
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_CORES*RATIO_W-1:0] core_req,
  input  logic [N_CORES-1:0]         core_sleep,
  input  logic [N_CORES-1:0]         core_ready,
  output logic [N_CORES*RATIO_W-1:0] core_ratio,
  output logic [RATIO_W-1:0]         target_ratio,
  output logic                       target_chg,
  output logic                       ratio_skew
);
  localparam ratio_t FLOOR_R = ratio_t'(FLOOR_RATIO);
  localparam ratio_t MAX_R   = ratio_t'(MAX_RATIO);

  ratio_t [N_CORES-1:0] req_lim;
  ratio_t [N_CORES-1:0] app_q;
  ratio_t [N_CORES-1:0] app_d;
  ratio_t               res_d;
  ratio_t               res_q;
  logic                 chg_d;
  logic                 chg_q;
  logic                 skew_d;
  logic                 skew_q;

  for (genvar g = 0; g < N_CORES; g++) begin : g_core
    ratio_clamp #(.LO(FLOOR_RATIO), .HI(MAX_RATIO)) u_clamp (
      .raw_i (core_req[g*RATIO_W +: RATIO_W]),
      .lim_o (req_lim[g])
    );

    core_apply_slot #(.FLOOR(FLOOR_RATIO)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .rdy_i   (core_ready[g]),
      .chg_i   (chg_d),
      .nxt_i   (res_d),
      .app_o   (app_q[g]),
      .app_d_o (app_d[g])
    );

    assign core_ratio[g*RATIO_W +: RATIO_W] = app_q[g];
  end

  active_max #(.N_CORES(N_CORES), .FLOOR(FLOOR_RATIO)) u_max (
    .lim_i   (req_lim),
    .sleep_i (core_sleep),
    .best_o  (res_d)
  );

  assign chg_d = (res_d != res_q);

  always_comb begin
    skew_d = 1'b0;
    for (int i = 0; i < N_CORES; i++) begin
      if (app_d[i] != res_d) skew_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= FLOOR_R;
      chg_q  <= 1'b0;
      skew_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      chg_q  <= chg_d;
      skew_q <= skew_d;
    end
  end

  assign target_ratio = res_q;
  assign target_chg   = chg_q;
  assign ratio_skew   = skew_q;

  assert_target_range_R4: assert property (@(posedge clk) disable iff (rst)
    (res_q >= FLOOR_R) && (res_q <= MAX_R));

  assert_all_asleep_floor_R3: assert property (@(posedge clk) disable iff (rst)
    $past(&core_sleep) |-> (res_q == FLOOR_R));

  assert_chg_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    chg_q == (res_q != $past(res_q)));

  assert_skew_match_R9: assert property (@(posedge clk) disable iff (rst)
    skew_q == (core_ratio != {N_CORES{res_q}}));
endmodule

// File: tb/sim_freq_resolver_top.sv
`timescale 1ns/1ps
module sim_freq_resolver_top;
  localparam int N = 4;
  localparam int W = 6;
  localparam int FL = 9;
  localparam int MX = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*W-1:0] core_req = '0;
  logic [N-1:0]   core_sleep = '1;
  logic [N-1:0]   core_ready = '0;
  logic [N*W-1:0] core_ratio;
  logic [W-1:0]   target_ratio;
  logic           target_chg;
  logic           ratio_skew;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_res, m_app[N], m_pr[N];
  bit m_pf[N];
  bit m_chg, m_skew;

  always #4 clk = ~clk;

  freq_resolver_top #(.N_CORES(N), .FLOOR_RATIO(FL), .MAX_RATIO(MX)) u0 (
    .clk(clk), .rst(rst), .core_req(core_req), .core_sleep(core_sleep),
    .core_ready(core_ready), .core_ratio(core_ratio),
    .target_ratio(target_ratio), .target_chg(target_chg), .ratio_skew(ratio_skew)
  );

  function automatic int lim(input int v);
    if (v < FL) return FL;
    if (v > MX) return MX;
    return v;
  endfunction

  function automatic int resolve(input logic [N*W-1:0] rq, input logic [N-1:0] sl);
    int best = FL;
    for (int i = 0; i < N; i++)
      if (!sl[i] && lim(int'(rq[i*W +: W])) > best) best = lim(int'(rq[i*W +: W]));
    return best;
  endfunction

  function automatic int app_of(input int i);
    return int'(core_ratio[i*W +: W]);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1 target", int'(target_ratio), m_res);
    check("R5 change pulse", int'(target_chg), int'(m_chg));
    for (int i = 0; i < N; i++) check("R7 applied", app_of(i), m_app[i]);
    check("R9 skew", int'(ratio_skew), int'(m_skew));
  endtask

  // Called on a falling edge: drive inputs, advance the model to the state
  // after the next rising edge, then compare on the following falling edge.
  task automatic step(input logic [N*W-1:0] rq, input logic [N-1:0] sl, input logic [N-1:0] rd);
    int nxt;
    bit chg;
    rst = 1'b0;
    core_req = rq; core_sleep = sl; core_ready = rd;
    nxt = resolve(rq, sl);
    chg = (nxt != m_res);
    m_skew = 0;
    for (int i = 0; i < N; i++) begin
      if (rd[i] && m_pf[i]) begin m_app[i] = m_pr[i]; m_pf[i] = 0; end
      if (chg) begin m_pf[i] = 1; m_pr[i] = nxt; end
    end
    m_res = nxt; m_chg = chg;
    for (int i = 0; i < N; i++) if (m_app[i] != m_res) m_skew = 1;
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [N*W-1:0] pack(input int a, input int b, input int c, input int d);
    return {W'(d), W'(c), W'(b), W'(a)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20260));
    m_res = FL; m_chg = 0; m_skew = 0;
    for (int i = 0; i < N; i++) begin m_app[i] = FL; m_pr[i] = FL; m_pf[i] = 0; end
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset target", int'(target_ratio), FL);
    check("R10 reset chg", int'(target_chg), 0);
    check("R10 reset skew", int'(ratio_skew), 0);
    for (int i = 0; i < N; i++) check("R10 reset applied", app_of(i), FL);

    // R3: every core asleep, high requests ignored
    step(pack(40, 30, 20, 25), 4'b1111, 4'b0000);
    check("R3 all asleep floor", int'(target_ratio), FL);
    // R4: low request clamps up to the floor
    step(pack(3, 0, 0, 0), 4'b1110, 4'b0000);
    check("R4 low clamp", int'(target_ratio), FL);
    // R4: high request clamps down to the maximum
    step(pack(60, 0, 0, 0), 4'b1110, 4'b0000);
    check("R4 high clamp", int'(target_ratio), MX);
    check("R6 applied held while pending", app_of(1), FL);
    check("R9 skew while pending", int'(ratio_skew), 1);
    // R2: core0 sleeps, core1 awake at 20; R8 pending replaced
    step(pack(60, 20, 0, 0), 4'b1101, 4'b0000);
    check("R2 sleeper excluded", int'(target_ratio), 20);
    step(pack(60, 20, 0, 0), 4'b1101, 4'b1111);
    for (int i = 0; i < N; i++) check("R8 newest pending applied", app_of(i), 20);
    check("R9 skew clear", int'(ratio_skew), 0);
    // R7: ready with nothing pending
    step(pack(60, 20, 0, 0), 4'b1101, 4'b1111);
    check("R7 idle ready no effect", app_of(0), 20);
    // R2: wake core0
    step(pack(60, 20, 0, 0), 4'b1100, 4'b0000);
    check("R2 wake counts", int'(target_ratio), MX);
    // R7: only core2 switches
    step(pack(60, 20, 0, 0), 4'b1100, 4'b0100);
    check("R7 independent core2", app_of(2), MX);
    check("R7 core0 still old", app_of(0), 20);

    for (int k = 0; k < 3000; k++) begin
      logic [N*W-1:0] rq;
      logic [N-1:0] sl, rd;
      for (int i = 0; i < N; i++) begin
        rq[i*W +: W] = W'($urandom_range(0, 63));
        sl[i] = ($urandom_range(0, 3) == 0);
        rd[i] = ($urandom_range(0, 2) == 0);
      end
      if ((k % 4) != 0) rq = core_req;
      step(rq, sl, rd);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule